// File: doc/BRIEF.md
# Interlace-Aware Scanline Interrupt Generator

This block watches a raster line counter and raises three interrupt pulses: two scanline interrupts whose targets software chooses, and one retrace interrupt at the top of every field. A separate raster counter drives the current line number, the odd/even field flag, the interlace mode and the total number of lines into the block. The block does not count lines itself.

Software places both scanline targets in one 32-bit position register. A target N names a line pair. It is turned into the raster line 2·N in an even field or 2·N+1 in an odd field. In interlaced mode, a target that is not ahead of the current line is placed in the opposite field's parity. When the resulting raster line is at or past the total line count, that interrupt is cancelled. It stays silent until something arms it again. Each interrupt re-arms itself after it fires. A write to the position register re-arms both scanline interrupts, and so does a strobe that reports a change of the total line count.

Top module: `scanline_irq`

## Requirements
- R1: The position register takes target A from write bits 25:16 and target B from write bits 9:0. A read returns target A in bits 25:16 and target B in bits 9:0, with every other bit zero.
- R2: With interlace off, a target N fires at raster line 2·N when the field flag is 0 (even) and at line 2·N+1 when the field flag is 1 (odd). The field flag used is the one present when the target is armed.
- R3: With interlace on, a target N that is less than or equal to the current line at arm time uses the inverted field flag for its parity. A target greater than the current line uses the field flag unchanged.
- R4: If the computed raster line is greater than or equal to the total line count at arm time, that interrupt never fires until it is re-armed.
- R5: The retrace output pulses each time the line input changes to 0.
- R6: An interrupt is a one-cycle pulse. It is high in the cycle after the first clock edge that samples the line input at its new matching value. It never fires while the line input stays unchanged.
- R7: After a scanline interrupt fires, it re-arms for the same target. The re-arm uses the line, field and interlace inputs present at the firing edge, so it fires again on a later pass.
- R8: A position register write, or a pulse on the total-change strobe, re-arms both scanline interrupts at once. The re-arm uses the current line, field, interlace and total inputs.
- R9: If the armed raster line equals the current line at arm time, no interrupt fires until the line input next changes to that value.
- R10: After reset all outputs are low and the position register reads 0. No scanline interrupt fires until the position register is written or the total strobe pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | LINE_W | Current raster line from the line counter |
| field_odd_i | input | 1 | Field flag, 1 = odd field |
| interlace_i | input | 1 | Interlaced scan mode |
| total_i | input | LINE_W | Total raster lines per field |
| pos_we_i | input | 1 | Write strobe for the position register |
| pos_wdata_i | input | 32 | Position register write data |
| total_we_i | input | 1 | Strobe: the total line count was written |
| pos_rdata_o | output | 32 | Position register read value |
| irq_a_o | output | 1 | Scanline interrupt for target A |
| irq_b_o | output | 1 | Scanline interrupt for target B |
| irq_retrace_o | output | 1 | Retrace interrupt at line 0 |

## Verification
The assertions check these properties on every cycle:
- every pulse lasts one cycle;
- a retrace pulse only follows line 0;
- a target A pulse lands on the line pair that target A names;
- a register write appears in the readback on the next cycle.

Only the bench's scenarios can show the behaviours that depend on history, which a single-cycle property cannot express:
- the choice of field parity at arm time;
- that an unreachable target stays silent for a whole field;
- that re-arming repeats on later frames;
- that a target equal to the current line waits a full pass.

A per-cycle reference model, running under random targets, totals and interlace settings, compares all three outputs.

// File: rtl/scanline_irq.sv
module scanline_irq #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_i,
  input  logic              field_odd_i,
  input  logic              interlace_i,
  input  logic [LINE_W-1:0] total_i,
  input  logic              pos_we_i,
  input  logic [31:0]       pos_wdata_i,
  input  logic              total_we_i,
  output logic [31:0]       pos_rdata_o,
  output logic              irq_a_o,
  output logic              irq_b_o,
  output logic              irq_retrace_o
);

  localparam int TW = 10;
  localparam int CW = (LINE_W > TW) ? LINE_W + 2 : TW + 2;

  logic [TW-1:0]     tgt_a, tgt_b;
  logic [LINE_W-1:0] line_q;
  logic              seen;
  logic [CW-1:0]     arm_a, arm_b;
  logic              ok_a, ok_b;

  function automatic logic [CW:0] place(input logic [TW-1:0] n,
                                        input logic [LINE_W-1:0] cur,
                                        input logic fld,
                                        input logic il,
                                        input logic [LINE_W-1:0] tot);
    logic          f;
    logic [CW-1:0] l;
    f = fld ^ (il && (CW'(n) <= CW'(cur)));
    l = (CW'(n) << 1) | CW'(f);
    return {(l < CW'(tot)), l};
  endfunction

  logic unused_bits;
  assign unused_bits = ^{pos_wdata_i[31:26], pos_wdata_i[15:10]};

  logic              moved, hit_a, hit_b, re_a, re_b;
  logic [TW-1:0]     nxt_a, nxt_b;
  logic [CW:0]       pa, pb;

  assign moved = seen && (line_i != line_q);
  assign hit_a = moved && ok_a && (CW'(line_i) == arm_a);
  assign hit_b = moved && ok_b && (CW'(line_i) == arm_b);
  assign nxt_a = pos_we_i ? pos_wdata_i[25:16] : tgt_a;
  assign nxt_b = pos_we_i ? pos_wdata_i[9:0]   : tgt_b;
  assign pa    = place(nxt_a, line_i, field_odd_i, interlace_i, total_i);
  assign pb    = place(nxt_b, line_i, field_odd_i, interlace_i, total_i);
  assign re_a  = pos_we_i || total_we_i || hit_a;
  assign re_b  = pos_we_i || total_we_i || hit_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen          <= 1'b0;
      line_q        <= '0;
      tgt_a         <= '0;
      tgt_b         <= '0;
      arm_a         <= '0;
      arm_b         <= '0;
      ok_a          <= 1'b0;
      ok_b          <= 1'b0;
      irq_a_o       <= 1'b0;
      irq_b_o       <= 1'b0;
      irq_retrace_o <= 1'b0;
    end else begin
      seen          <= 1'b1;
      line_q        <= line_i;
      irq_a_o       <= hit_a;
      irq_b_o       <= hit_b;
      irq_retrace_o <= moved && (line_i == '0);
      tgt_a         <= nxt_a;
      tgt_b         <= nxt_b;
      if (re_a) {ok_a, arm_a} <= pa;
      if (re_b) {ok_b, arm_b} <= pb;
    end
  end

  assign pos_rdata_o = {6'd0, tgt_a, 6'd0, tgt_b};

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a_o || irq_b_o || irq_retrace_o) |=> !(irq_a_o || irq_b_o || irq_retrace_o)
      || $changed(line_q));

  assert_a_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a_o |=> !irq_a_o);

  assert_retrace_line0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_retrace_o |-> (line_q == '0));

  assert_hit_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a_o && !$past(pos_we_i)) |-> (CW'(line_q >> 1) == CW'(tgt_a)));

  assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pos_we_i |=> (pos_rdata_o[25:16] == $past(pos_wdata_i[25:16]))
              && (pos_rdata_o[9:0] == $past(pos_wdata_i[9:0])));

endmodule

// File: tb/scanline_irq_tb.sv
module scanline_irq_tb_top;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  line_i = '0;
  logic        field_odd_i = 1'b0;
  logic        interlace_i = 1'b0;
  logic [9:0]  total_i = 10'd40;
  logic        pos_we_i = 1'b0;
  logic [31:0] pos_wdata_i = '0;
  logic        total_we_i = 1'b0;
  logic [31:0] pos_rdata_o;
  logic        irq_a_o, irq_b_o, irq_retrace_o;

  always #10 clk = ~clk;

  scanline_irq dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .field_odd_i(field_odd_i),
    .interlace_i(interlace_i), .total_i(total_i), .pos_we_i(pos_we_i),
    .pos_wdata_i(pos_wdata_i), .total_we_i(total_we_i), .pos_rdata_o(pos_rdata_o),
    .irq_a_o(irq_a_o), .irq_b_o(irq_b_o), .irq_retrace_o(irq_retrace_o));

  int vectors = 0, fails = 0;
  int cyc_vec = 0, cyc_fail = 0;
  int cnt_a = 0, cnt_b = 0, cnt_r = 0;
  int last_a = -1, last_b = -1;
  int run_a = 0, run_b = 0, run_r = 0, max_run = 0;
  bit done = 1'b0;

  function automatic logic [12:0] exp_arm(input logic [9:0] n, input logic [9:0] cur,
                                          input logic fld, input logic il,
                                          input logic [9:0] tot);
    logic f;
    logic [11:0] l;
    f = fld;
    if (il && n <= cur) f = ~f;
    l = 12'(n) * 2 + 12'(f);
    return {(l < 12'(tot)), l};
  endfunction

  logic [9:0]  m_ta = '0, m_tb = '0, m_lq = '0;
  logic [12:0] m_aa = '0, m_ab = '0;
  logic        m_seen = 1'b0, e_a = 1'b0, e_b = 1'b0, e_r = 1'b0;

  always @(posedge clk) begin : ref_model
    logic chg, fa, fb;
    logic [9:0] na, nb;
    if (!rst_n) begin
      m_ta <= '0; m_tb <= '0; m_lq <= '0; m_aa <= '0; m_ab <= '0;
      m_seen <= 1'b0; e_a <= 1'b0; e_b <= 1'b0; e_r <= 1'b0;
    end else begin
      chg = m_seen && (line_i != m_lq);
      fa  = chg && m_aa[12] && (12'(line_i) == m_aa[11:0]);
      fb  = chg && m_ab[12] && (12'(line_i) == m_ab[11:0]);
      e_a <= fa;
      e_b <= fb;
      e_r <= chg && (line_i == 0);
      m_lq <= line_i;
      m_seen <= 1'b1;
      na = pos_we_i ? pos_wdata_i[25:16] : m_ta;
      nb = pos_we_i ? pos_wdata_i[9:0] : m_tb;
      m_ta <= na;
      m_tb <= nb;
      if (pos_we_i || total_we_i || fa)
        m_aa <= exp_arm(na, line_i, field_odd_i, interlace_i, total_i);
      if (pos_we_i || total_we_i || fb)
        m_ab <= exp_arm(nb, line_i, field_odd_i, interlace_i, total_i);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      cyc_vec = cyc_vec + 1;
      if ({irq_a_o, irq_b_o, irq_retrace_o} != {e_a, e_b, e_r}) begin
        cyc_fail = cyc_fail + 1;
        $display("FAIL R6 per-cycle irq {a,b,r} actual=%b expected=%b at line %0d",
                 {irq_a_o, irq_b_o, irq_retrace_o}, {e_a, e_b, e_r}, line_i);
      end
    end
    if (irq_a_o) begin cnt_a = cnt_a + 1; last_a = int'(line_i); end
    if (irq_b_o) begin cnt_b = cnt_b + 1; last_b = int'(line_i); end
    if (irq_retrace_o) cnt_r = cnt_r + 1;
    run_a = irq_a_o ? run_a + 1 : 0;
    run_b = irq_b_o ? run_b + 1 : 0;
    run_r = irq_retrace_o ? run_r + 1 : 0;
    if (run_a > max_run) max_run = run_a;
    if (run_b > max_run) max_run = run_b;
    if (run_r > max_run) max_run = run_r;
  end

  int cur_line = 0;
  bit cur_field = 1'b0;
  int total = 40;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors = vectors + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_line();
    @(negedge clk);
    cur_line = cur_line + 1;
    if (cur_line >= total) begin
      cur_line = 0;
      if (interlace_i) cur_field = ~cur_field;
    end
    line_i = 10'(cur_line);
    field_odd_i = cur_field;
    repeat (H - 1) @(negedge clk);
  endtask

  task automatic run_lines(input int n);
    for (int i = 0; i < n; i++) step_line();
  endtask

  task automatic set_line(input int l);
    @(negedge clk);
    cur_line = l;
    line_i = 10'(l);
    repeat (H - 1) @(negedge clk);
  endtask

  task automatic write_pos(input logic [31:0] w);
    @(negedge clk);
    pos_we_i = 1'b1;
    pos_wdata_i = w;
    @(negedge clk);
    pos_we_i = 1'b0;
  endtask

  task automatic strobe_total();
    @(negedge clk);
    total_we_i = 1'b1;
    @(negedge clk);
    total_we_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors + cyc_vec, fails + cyc_fail);
    $finish;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int ba, bb, br;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk({irq_a_o, irq_b_o, irq_retrace_o} == 3'b000, "R10 outputs in reset",
        int'({irq_a_o, irq_b_o, irq_retrace_o}), 0);
    chk(pos_rdata_o == 0, "R10 register after reset", int'(pos_rdata_o), 0);
    rst_n = 1'b1;

    ba = cnt_a; bb = cnt_b; br = cnt_r;
    run_lines(50);
    chk(cnt_a == ba && cnt_b == bb, "R10 no scanline irq before arming", cnt_a + cnt_b - ba - bb, 0);
    chk(cnt_r - br == 1, "R5 retrace once per wrap", cnt_r - br, 1);

    write_pos(32'hFFFF_FFFF);
    chk(pos_rdata_o == 32'h03FF_03FF, "R1 readback mask", int'(pos_rdata_o), 32'h03FF_03FF);
    write_pos(32'hFC05_FC07);
    chk(pos_rdata_o == 32'h0005_0007, "R1 field placement", int'(pos_rdata_o), 32'h0005_0007);

    ba = cnt_a;
    repeat (3) @(negedge clk);
    chk(cnt_a == ba, "R9 no fire on current line", cnt_a - ba, 0);

    ba = cnt_a; bb = cnt_b;
    run_lines(40);
    chk(cnt_a - ba == 1, "R9 fires on next pass", cnt_a - ba, 1);
    chk(last_a == 10, "R2 even field line 2N", last_a, 10);
    chk(cnt_b - bb == 1 && last_b == 14, "R2 even field target B", last_b, 14);

    ba = cnt_a;
    run_lines(40);
    chk(cnt_a - ba == 1, "R7 re-arms after firing", cnt_a - ba, 1);

    cur_field = 1'b1; field_odd_i = 1'b1;
    write_pos(32'h0005_0007);
    ba = cnt_a; bb = cnt_b;
    run_lines(40);
    chk(cnt_a - ba == 1 && last_a == 11, "R2 odd field line 2N+1", last_a, 11);
    chk(cnt_b - bb == 1 && last_b == 15, "R2 odd field target B", last_b, 15);

    interlace_i = 1'b1; cur_field = 1'b0; field_odd_i = 1'b0;
    set_line(20);
    write_pos((32'd5 << 16) | 32'd30);
    ba = cnt_a; bb = cnt_b;
    run_lines(40);
    chk(cnt_a - ba == 1 && last_a == 11, "R3 opposite parity when behind", last_a, 11);
    chk(cnt_b == bb, "R4 line 60 beyond total 40", cnt_b - bb, 0);

    interlace_i = 1'b0; cur_field = 1'b0; field_odd_i = 1'b0;
    write_pos(32'd25 << 16);
    ba = cnt_a;
    run_lines(40);
    chk(cnt_a == ba, "R4 cancelled target", cnt_a - ba, 0);
    total = 60; total_i = 10'd60;
    run_lines(60);
    chk(cnt_a == ba, "R4 stays cancelled without re-arm", cnt_a - ba, 0);
    strobe_total();
    run_lines(60);
    chk(cnt_a - ba == 1 && last_a == 50, "R8 total strobe re-arms", last_a, 50);

    br = cnt_r;
    run_lines(60);
    chk(cnt_r - br == 1, "R5 retrace per field", cnt_r - br, 1);

    for (int it = 0; it < 40; it++) begin
      total = 16 + int'($urandom % 40);
      total_i = 10'(total);
      interlace_i = 1'($urandom % 2);
      write_pos(($urandom & 32'hFC00_FC00) | ((($urandom % 40)) << 16) | ($urandom % 40));
      if ($urandom % 3 == 0) strobe_total();
      run_lines(2 * total + 5);
    end

    chk(max_run == 1, "R6 pulse width", max_run, 1);
    done = 1'b1;
    finish_run();
  end
endmodule